// File: doc/BRIEF.md
# Wait-Pin Ready Transition Detector

This block watches a set of external wait/ready lines driven by NAND flash devices. Each line is brought into the clock domain through a multi-flop synchronizer. Its synchronized level is always visible in a live status register. A sticky flag per line records the moment the device leaves its busy (wait) state. A per-line polarity bit defines which level means "wait", and therefore which edge counts as the release. Software clears a flag by writing 1 to it. A per-line mask selects which flags drive the single interrupt output, so software can sleep through a long page opening instead of polling.

The same synchronized levels also feed a stall output for an access engine. Each chip-select has its own read-monitoring and write-monitoring enable and its own choice of wait line. An access is stalled only when monitoring is enabled for its direction and its selected line is in the wait state. The enables gate only the stall. Status capture and flag detection run whether or not any monitoring is enabled.

Software uses a plain write/read port. One word address selects a register, and read data is combinational from the address.

Top module: `wait_ready_monitor`

## Requirements
- R1: Status register (address 0) bit i shows the level of wait line i as it was sampled at the previous clock edge, so a change is visible after two rising edges. It reads 0 during reset and is captured regardless of every monitoring enable.
- R2: With polarity bit i = 0 (line active low, wait = low), a low-to-high change on line i sets flag i in the flag register (address 1) at the third rising edge after the change.
- R3: With polarity bit i = 1 (line active high, wait = high), a high-to-low change on line i sets flag i. Polarity bits sit at address 3, bit i.
- R4: A change into the wait state, or a polarity write while the line is stable, never sets a flag.
- R5: A set flag stays set until software writes 1 to its bit at address 1. Writing 0 to a flag bit leaves it unchanged.
- R6: When a qualifying release and a write-1 clear of the same flag land on the same edge, the flag ends set.
- R7: irq is high exactly when some flag i is set and mask bit i (address 2, bit i) is 1.
- R8: stall is high when acc_valid is high, the monitoring enable for the access direction of acc_cs is 1, and the wait line selected for acc_cs is in its wait state. Address 4 holds read enables in bits [7:0] (bit c = chip-select c) and write enables in bits [15:8]. Address 5 holds a 2-bit line number for chip-select c at bits [2c+1:2c].
- R9: When monitoring is disabled for the access direction of the chip-select, stall stays low whatever the wait lines do.
- R10: After reset, all registers, flags and irq are 0. No flag is set until both the current and the previous synchronized samples come from after reset, so a line that already sits released at reset produces no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_pins_i | input | 4 | Asynchronous wait/ready lines from the devices |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| acc_valid_i | input | 1 | An access is being presented |
| acc_cs_i | input | 3 | Chip-select of the access |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| stall_o | output | 1 | Hold the access: selected line is in wait and monitored |
| irq_o | output | 1 | OR of unmasked flags |

## Verification
On every cycle the assertions check four things: that a flag only rises after a release edge in the direction given by the line's polarity, that flags never drop without a clear write, that no flag appears before the synchronizer is primed, and that irq and stall respect the mask and the monitoring enables. Only the bench scenarios can show the exact latency from line change to status and flag, that set wins over a simultaneous clear, that status keeps following lines with monitoring disabled, and that the per-chip-select line selection routes the right line to stall. The bench checks these against a behavioural model compared on every clock.

// File: rtl/wrm_pkg.sv
package wrm_pkg;

   localparam int WRM_ADDR_W = 3;

   typedef enum logic [WRM_ADDR_W-1:0] {
      ADDR_STATUS  = 3'd0,
      ADDR_FLAGS   = 3'd1,
      ADDR_MASK    = 3'd2,
      ADDR_POL     = 3'd3,
      ADDR_MON_EN  = 3'd4,
      ADDR_PIN_SEL = 3'd5
   } wrm_addr_e;

   // level means "device busy" for the given polarity (1 = active high)
   function automatic logic wait_active(input logic level, input logic active_high);
      return active_high ? level : ~level;
   endfunction

   // busy -> ready transition between two successive samples
   function automatic logic released(input logic prev, input logic cur, input logic active_high);
      return wait_active(prev, active_high) & ~wait_active(cur, active_high);
   endfunction

endpackage

// File: rtl/wrm_sync.sv
module wrm_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o,
   output logic             primed_o
);
   localparam int CNT_MAX = STAGES + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic [WIDTH-1:0] chain_q [STAGES];
   logic [WIDTH-1:0] prev_q;
   logic [CNT_W-1:0] fill_q;

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[k] <= '0;
               else        chain_q[k] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[k] <= '0;
               else        chain_q[k] <= chain_q[k-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         fill_q <= '0;
      end else begin
         prev_q <= chain_q[STAGES-1];
         if (fill_q != CNT_W'(CNT_MAX)) fill_q <= fill_q + 1'b1;
      end
   end

   assign cur_o    = chain_q[STAGES-1];
   assign prev_o   = prev_q;
   assign primed_o = (fill_q == CNT_W'(CNT_MAX));
endmodule

// File: rtl/wrm_edge_flags.sv
module wrm_edge_flags
   import wrm_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                primed_i,
   input  logic [NUM_PINS-1:0] cur_i,
   input  logic [NUM_PINS-1:0] prev_i,
   input  logic [NUM_PINS-1:0] pol_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] flags_o
);
   genvar i;
   generate
      for (i = 0; i < NUM_PINS; i++) begin : g_pin
         logic hit;
         logic flag_q;
         assign hit = primed_i & released(prev_i[i], cur_i[i], pol_i[i]);
         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= hit | (flag_q & ~clr_i[i]);
         end
         assign flags_o[i] = flag_q;
      end
   endgenerate
endmodule

// File: rtl/wrm_regfile.sv
module wrm_regfile
   import wrm_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CS   = 8,
   parameter int SEL_W    = 2,
   parameter int DATA_W   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [WRM_ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic [NUM_PINS-1:0]     status_i,
   input  logic [NUM_PINS-1:0]     flags_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic [NUM_PINS-1:0]     clr_o,
   output logic [NUM_PINS-1:0]     mask_o,
   output logic [NUM_PINS-1:0]     pol_o,
   output logic [NUM_CS-1:0]       rd_en_o,
   output logic [NUM_CS-1:0]       wr_en_o,
   output logic [NUM_CS*SEL_W-1:0] sel_o
);
   localparam int SEL_BITS = NUM_CS * SEL_W;

   logic [NUM_PINS-1:0] mask_q, pol_q;
   logic [NUM_CS-1:0]   rd_en_q, wr_en_q;
   logic [SEL_BITS-1:0] sel_q;
   logic                unused_wdata_bits;

   assign unused_wdata_bits = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         pol_q   <= '0;
         rd_en_q <= '0;
         wr_en_q <= '0;
         sel_q   <= '0;
      end else if (we_i) begin
         case (addr_i)
            ADDR_MASK:    mask_q <= wdata_i[NUM_PINS-1:0];
            ADDR_POL:     pol_q  <= wdata_i[NUM_PINS-1:0];
            ADDR_MON_EN: begin
               rd_en_q <= wdata_i[NUM_CS-1:0];
               wr_en_q <= wdata_i[2*NUM_CS-1:NUM_CS];
            end
            ADDR_PIN_SEL: sel_q  <= wdata_i[SEL_BITS-1:0];
            default: ;
         endcase
      end
   end

   assign clr_o = (we_i && addr_i == ADDR_FLAGS) ? wdata_i[NUM_PINS-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_STATUS:  rdata_o[NUM_PINS-1:0]   = status_i;
         ADDR_FLAGS:   rdata_o[NUM_PINS-1:0]   = flags_i;
         ADDR_MASK:    rdata_o[NUM_PINS-1:0]   = mask_q;
         ADDR_POL:     rdata_o[NUM_PINS-1:0]   = pol_q;
         ADDR_MON_EN:  rdata_o[2*NUM_CS-1:0]   = {wr_en_q, rd_en_q};
         ADDR_PIN_SEL: rdata_o[SEL_BITS-1:0]   = sel_q;
         default: ;
      endcase
   end

   assign mask_o  = mask_q;
   assign pol_o   = pol_q;
   assign rd_en_o = rd_en_q;
   assign wr_en_o = wr_en_q;
   assign sel_o   = sel_q;
endmodule

// File: rtl/wrm_stall.sv
module wrm_stall
   import wrm_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CS   = 8,
   parameter int SEL_W    = 2,
   parameter int CS_W     = 3
) (
   input  logic                    acc_valid_i,
   input  logic [CS_W-1:0]         acc_cs_i,
   input  logic                    acc_write_i,
   input  logic [NUM_PINS-1:0]     status_i,
   input  logic [NUM_PINS-1:0]     pol_i,
   input  logic [NUM_CS-1:0]       rd_en_i,
   input  logic [NUM_CS-1:0]       wr_en_i,
   input  logic [NUM_CS*SEL_W-1:0] sel_i,
   output logic                    stall_o
);
   logic [NUM_CS-1:0] cs_busy;
   logic [NUM_CS-1:0] cs_on;

   genvar c;
   generate
      for (c = 0; c < NUM_CS; c++) begin : g_cs
         logic [SEL_W-1:0] line;
         assign line       = sel_i[c*SEL_W +: SEL_W];
         assign cs_busy[c] = wait_active(status_i[line], pol_i[line]);
         assign cs_on[c]   = acc_write_i ? wr_en_i[c] : rd_en_i[c];
      end
   endgenerate

   assign stall_o = acc_valid_i & cs_on[acc_cs_i] & cs_busy[acc_cs_i];
endmodule

// File: rtl/wait_ready_monitor.sv
module wait_ready_monitor
   import wrm_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int NUM_CS      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 32,
   localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   wait_pins_i,
   input  logic                  reg_we_i,
   input  logic [WRM_ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   input  logic                  acc_valid_i,
   input  logic [CS_W-1:0]       acc_cs_i,
   input  logic                  acc_write_i,
   output logic                  stall_o,
   output logic                  irq_o
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
         $error("NUM_PINS must be 1..DATA_W");
      end
      if (2 * NUM_CS > DATA_W || NUM_CS * SEL_W > DATA_W) begin : g_bad_cs
         $error("chip-select fields do not fit in DATA_W");
      end
      if ((1 << CS_W) != NUM_CS) begin : g_bad_cs_pow2
         $error("NUM_CS must be a power of two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0]     status_q, prev_q, flags_q, clr;
   logic [NUM_PINS-1:0]     mask_q, pol_q;
   logic [NUM_CS-1:0]       rd_en_q, wr_en_q;
   logic [NUM_CS*SEL_W-1:0] sel_q;
   logic                    primed;

   wrm_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk, .rst_n, .async_i(wait_pins_i),
      .cur_o(status_q), .prev_o(prev_q), .primed_o(primed)
   );

   wrm_edge_flags #(.NUM_PINS(NUM_PINS)) flags_i (
      .clk, .rst_n, .primed_i(primed), .cur_i(status_q), .prev_i(prev_q),
      .pol_i(pol_q), .clr_i(clr), .flags_o(flags_q)
   );

   wrm_regfile #(.NUM_PINS(NUM_PINS), .NUM_CS(NUM_CS), .SEL_W(SEL_W), .DATA_W(DATA_W)) regs_i (
      .clk, .rst_n, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .status_i(status_q), .flags_i(flags_q), .rdata_o(reg_rdata_o), .clr_o(clr),
      .mask_o(mask_q), .pol_o(pol_q), .rd_en_o(rd_en_q), .wr_en_o(wr_en_q), .sel_o(sel_q)
   );

   wrm_stall #(.NUM_PINS(NUM_PINS), .NUM_CS(NUM_CS), .SEL_W(SEL_W), .CS_W(CS_W)) stall_i (
      .acc_valid_i, .acc_cs_i, .acc_write_i, .status_i(status_q), .pol_i(pol_q),
      .rd_en_i(rd_en_q), .wr_en_i(wr_en_q), .sel_i(sel_q), .stall_o
   );

   assign irq_o = |(flags_q & mask_q);
endmodule

// File: rtl/wrm_checker.sv
module wrm_checker
   import wrm_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CS   = 8,
   parameter int CS_W     = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_PINS-1:0]   status,
   input logic [NUM_PINS-1:0]   flags,
   input logic [NUM_PINS-1:0]   mask,
   input logic [NUM_PINS-1:0]   pol,
   input logic                  primed,
   input logic                  we,
   input logic [WRM_ADDR_W-1:0] addr,
   input logic                  irq,
   input logic                  acc_valid,
   input logic [CS_W-1:0]       acc_cs,
   input logic                  acc_write,
   input logic [NUM_CS-1:0]     rd_en,
   input logic [NUM_CS-1:0]     wr_en,
   input logic                  stall
);
   // R5: without a clear write, no set flag drops
   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == ADDR_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));

   // R10: nothing flagged before the synchronizer holds two post-reset samples
   assert_quiet_until_primed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> (flags == '0));

   // R7
   assert_no_irq_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);
   assert_irq_on_unmasked_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & mask) != '0) |-> irq);

   // R9
   assert_no_stall_unmonitored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(acc_write ? wr_en[acc_cs] : rd_en[acc_cs])) |-> !stall);

   // R8: stall only during an access
   assert_stall_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> acc_valid);

   genvar i;
   generate
      for (i = 0; i < NUM_PINS; i++) begin : g_pin
         // R2 and R3: a flag rises only after a busy-to-ready step of its line
         assert_flag_rise_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |->
               ($past(pol[i]) ? ($past(status[i], 2) && !$past(status[i]))
                              : (!$past(status[i], 2) && $past(status[i]))));
      end
   endgenerate
endmodule

bind wait_ready_monitor wrm_checker #(.NUM_PINS(NUM_PINS), .NUM_CS(NUM_CS), .CS_W(CS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .status(status_q), .flags(flags_q), .mask(mask_q),
   .pol(pol_q), .primed(primed), .we(reg_we_i), .addr(reg_addr_i), .irq(irq_o),
   .acc_valid(acc_valid_i), .acc_cs(acc_cs_i), .acc_write(acc_write_i),
   .rd_en(rd_en_q), .wr_en(wr_en_q), .stall(stall_o)
);

// File: tb/wait_ready_monitor_tb_top.sv
module wait_ready_monitor_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pins = 4'hF;
   logic        we = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        acc_valid = 1'b0;
   logic [2:0]  acc_cs = 3'd0;
   logic        acc_write = 1'b0;
   logic        stall, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wait_ready_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .wait_pins_i(pins), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .acc_valid_i(acc_valid),
      .acc_cs_i(acc_cs), .acc_write_i(acc_write), .stall_o(stall), .irq_o(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [3:0]  hist[$];
   logic [3:0]  m_flags = '0, m_mask = '0, m_pol = '0;
   logic [15:0] m_en = '0, m_sel = '0;

   function automatic logic [3:0] m_status();
      return (hist.size() >= 2) ? hist[hist.size()-2] : 4'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         m_flags = '0; m_mask = '0; m_pol = '0; m_en = '0; m_sel = '0;
      end else begin
         logic [3:0] setv, clrv;
         setv = '0;
         clrv = '0;
         if (hist.size() >= 3) begin
            logic [3:0] c, p;
            c = hist[hist.size()-2];
            p = hist[hist.size()-3];
            for (int i = 0; i < 4; i++)
               setv[i] = m_pol[i] ? (p[i] && !c[i]) : (!p[i] && c[i]);
         end
         if (we) begin
            case (addr)
               3'd1: clrv   = wdata[3:0];
               3'd2: m_mask = wdata[3:0];
               3'd3: m_pol  = wdata[3:0];
               3'd4: m_en   = wdata[15:0];
               3'd5: m_sel  = wdata[15:0];
               default: ;
            endcase
         end
         m_flags = setv | (m_flags & ~clrv);
         hist.push_back(pins);
         while (hist.size() > 3) void'(hist.pop_front());
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [31:0] exp_rd;
         logic [3:0]  st;
         int line;
         logic busy, on;
         st = m_status();
         case (addr)
            3'd0: exp_rd = {28'h0, st};
            3'd1: exp_rd = {28'h0, m_flags};
            3'd2: exp_rd = {28'h0, m_mask};
            3'd3: exp_rd = {28'h0, m_pol};
            3'd4: exp_rd = {16'h0, m_en};
            3'd5: exp_rd = {16'h0, m_sel};
            default: exp_rd = '0;
         endcase
         check((addr == 3'd1) ? "R5 model flags" : "R1 model rdata", rdata, exp_rd);
         check("R7 model irq", {31'h0, irq}, {31'h0, |(m_flags & m_mask)});
         line = int'((m_sel >> (2*acc_cs)) & 16'h3);
         busy = m_pol[line] ? st[line] : !st[line];
         on   = acc_write ? m_en[8 + acc_cs] : m_en[acc_cs];
         check("R8 model stall", {31'h0, stall}, {31'h0, acc_valid && on && busy});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd_expect(input string tag, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #2 check(tag, rdata, exp);
   endtask

   task automatic set_pin(input int i, input logic v);
      @(negedge clk);
      pins[i] = v;
      cycles(4);
   endtask

   task automatic acc_expect(input string tag, input logic [2:0] cs, input logic w, input logic exp);
      @(negedge clk);
      acc_valid = 1'b1; acc_cs = cs; acc_write = w;
      #2 check(tag, {31'h0, stall}, {31'h0, exp});
   endtask

   initial begin
      // R10: reset state
      cycles(3);
      addr = 3'd0;
      #2 check("R10 status in reset", rdata, 32'h0);
      check("R10 irq in reset", {31'h0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      cycles(5);
      rd_expect("R1 status follows lines", 3'd0, 32'hF);
      rd_expect("R10 no flag for line released at reset", 3'd1, 32'h0);

      // R2 / R4: active low
      set_pin(0, 1'b0);
      rd_expect("R4 entering wait sets nothing", 3'd1, 32'h0);
      set_pin(0, 1'b1);
      rd_expect("R2 low-to-high sets flag0", 3'd1, 32'h1);
      set_pin(1, 1'b0);
      rd_expect("R4 high-to-low on active-low line", 3'd1, 32'h1);
      set_pin(1, 1'b1);
      rd_expect("R2 release on line1", 3'd1, 32'h3);

      // R5
      wr(3'd1, 32'h0);
      rd_expect("R5 write 0 keeps flags", 3'd1, 32'h3);
      wr(3'd1, 32'h1);
      rd_expect("R5 write 1 clears flag0", 3'd1, 32'h2);

      // R3 / R4: active high on line 2
      wr(3'd3, 32'h4);
      cycles(3);
      rd_expect("R4 polarity write with stable line", 3'd1, 32'h2);
      set_pin(2, 1'b0);
      rd_expect("R3 high-to-low sets flag2", 3'd1, 32'h6);
      set_pin(2, 1'b1);
      rd_expect("R4 low-to-high on active-high line", 3'd1, 32'h6);

      // R7
      #1 check("R7 irq with mask 0", {31'h0, irq}, 32'h0);
      wr(3'd2, 32'h4);
      #1 check("R7 irq with flag2 unmasked", {31'h0, irq}, 32'h1);
      wr(3'd1, 32'h4);
      #1 check("R7 irq after clearing flag2", {31'h0, irq}, 32'h0);
      wr(3'd2, 32'h2);
      #1 check("R7 irq via flag1", {31'h0, irq}, 32'h1);
      wr(3'd2, 32'h0);

      // R6: release and clear on the same edge
      wr(3'd1, 32'hF);
      rd_expect("R5 clear all", 3'd1, 32'h0);
      set_pin(3, 1'b0);
      @(negedge clk); pins[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 32'h8;
      @(negedge clk); we = 1'b0; wdata = '0;
      #2 check("R6 set wins over clear", rdata, 32'h8);
      wr(3'd1, 32'h8);
      rd_expect("R5 later clear of flag3", 3'd1, 32'h0);

      // R8 / R9 / R1
      wr(3'd5, 32'h800);   // cs5 -> line 2, cs0 -> line 0
      wr(3'd4, 32'h2001);  // read monitor cs0, write monitor cs5
      set_pin(0, 1'b0);
      rd_expect("R1 status with monitoring partly off", 3'd0, 32'hE);
      acc_expect("R8 read cs0 line0 busy", 3'd0, 1'b0, 1'b1);
      acc_expect("R9 write cs0 unmonitored", 3'd0, 1'b1, 1'b0);
      acc_expect("R8 write cs5 line2 busy active-high", 3'd5, 1'b1, 1'b1);
      acc_expect("R9 read cs5 unmonitored", 3'd5, 1'b0, 1'b0);
      acc_expect("R9 cs3 unmonitored", 3'd3, 1'b0, 1'b0);
      @(negedge clk); acc_valid = 1'b0;
      #2 check("R8 no access no stall", {31'h0, stall}, 32'h0);
      set_pin(0, 1'b1);
      acc_expect("R8 read cs0 line0 ready", 3'd0, 1'b0, 1'b0);
      @(negedge clk); acc_valid = 1'b0;
      rd_expect("R2 flag0 with monitoring on", 3'd1, 32'h1);
      wr(3'd4, 32'h0);
      set_pin(2, 1'b0);
      rd_expect("R1 status with monitoring off", 3'd0, 32'hB);
      acc_expect("R9 all monitoring off", 3'd5, 1'b1, 1'b0);
      @(negedge clk); acc_valid = 1'b0;

      cycles(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule